// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits beside a parallel flash-style memory and inspects every byte write the host makes. A write changes nothing in the array unless it belongs to a three-write unlock handshake. The first write of the handshake carries key AAh to address 5555h and the second carries key 55h to address 2AAAh. The third write carries an opcode to 5555h, and that opcode asks for one of three things: loading of a sector for programming, entry into identification mode, or exit from identification mode.

Each recognised action is reported as a one-cycle pulse. While identification mode is active, the block supplies the manufacturer code and the device code on a read port. A write that does not belong to any handshake is also reported. The surrounding logic uses that report to start the busy timer, which blocks reads while the array stays untouched. After a programming unlock, the writes that follow are sector data loads. The block ignores them until the memory signals that the program cycle has ended, and from then on the next program operation needs a fresh unlock.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, id_mode is 0, id_data reads 00h, and no pulse output is high. Reset also clears identification mode.
- R2: Only address bits 14 to 0 take part in the address compare, so bit 15 has no effect on matching. The first key write is AAh to 5555h and the second key write is 55h to 2AAAh.
- R3: A third write of A0h to 5555h, directly after the two key writes, raises program_enable for exactly the cycle after that write.
- R4: A third write of 90h to 5555h, after the two keys, pulses id_enter in the cycle after the write, and id_mode is 1 from that cycle on.
- R5: A third write of F0h to 5555h, after the two keys, pulses id_exit in the cycle after the write, and id_mode is 0 from that cycle on.
- R6: While id_mode is 1, id_data shows 1Fh when rd_addr bit 0 is 0 and 3Dh when it is 1. While id_mode is 0, id_data shows 00h.
- R7: A write that is neither part of a handshake nor a sector load pulses bare_write in the cycle after the write.
- R8: If a write in the middle of a handshake does not match, the handshake is abandoned. That same write is then judged as a possible first key, so a write of AAh to 5555h starts a new handshake, and any other write pulses bare_write.
- R9: After program_enable, writes are sector loads and produce no pulse, until prog_done is seen. A prog_done seen in the same cycle as a write means that write is judged as a first key. After prog_done, programming again needs all three writes.
- R10: At most one of program_enable, id_enter, id_exit and bare_write is high in any cycle, and each of them is high only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | Program cycle ended; re-arms protection |
| rd_addr | input | 16 | Read address; bit 0 selects the identification code |
| program_enable | output | 1 | Pulse: sector load unlocked |
| id_enter | output | 1 | Pulse: identification mode entered |
| id_exit | output | 1 | Pulse: identification mode left |
| bare_write | output | 1 | Pulse: unprotected write, start the busy timer |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification code for rd_addr |

## Verification
The handshake progress is hidden, so a wrong internal step only shows on a later write. It appears either as a pulse missing from the cycle after a third write, or as a bare_write pulse where none belongs. A wrong id_mode shows at once on id_data, for either value of rd_addr bit 0. A load phase that never ends, or ends too early, shows within one write after prog_done, through a missing or extra bare_write pulse. The bench follows every write with a model and compares every output in the cycle after it, so a divergence is reported on the first write that exposes it.

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CMP_BITS = 15,
  parameter logic [AW-1:0] ADDR_A = 16'h5555,
  parameter logic [AW-1:0] ADDR_B = 16'h2AAA,
  parameter logic [DW-1:0] KEY1 = 8'hAA,
  parameter logic [DW-1:0] KEY2 = 8'h55,
  parameter logic [DW-1:0] OP_PROG = 8'hA0,
  parameter logic [DW-1:0] OP_ID_IN = 8'h90,
  parameter logic [DW-1:0] OP_ID_OUT = 8'hF0,
  parameter logic [DW-1:0] MFR_CODE = 8'h1F,
  parameter logic [DW-1:0] DEV_CODE = 8'h3D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_done,
  input  logic [AW-1:0] rd_addr,
  output logic          program_enable,
  output logic          id_enter,
  output logic          id_exit,
  output logic          bare_write,
  output logic          id_mode,
  output logic [DW-1:0] id_data
);
  localparam logic [AW-1:0] CMP_MASK = {{(AW-CMP_BITS){1'b0}}, {CMP_BITS{1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_KEY1, S_KEY2, S_LOAD} st_t;
  st_t st, cur, nxt;

  logic hit_a, hit_b, is_first, is_second;
  logic nx_prog, nx_in, nx_out, nx_bare;

  assign hit_a     = ((wr_addr ^ ADDR_A) & CMP_MASK) == '0;
  assign hit_b     = ((wr_addr ^ ADDR_B) & CMP_MASK) == '0;
  assign is_first  = hit_a && (wr_data == KEY1);
  assign is_second = hit_b && (wr_data == KEY2);
  assign cur       = (st == S_LOAD && prog_done) ? S_IDLE : st;

  always_comb begin
    nxt     = cur;
    nx_prog = 1'b0;
    nx_in   = 1'b0;
    nx_out  = 1'b0;
    nx_bare = 1'b0;
    if (wr_en) begin
      unique case (cur)
        S_LOAD: nxt = S_LOAD;
        S_KEY1:
          if (is_second) nxt = S_KEY2;
          else if (is_first) nxt = S_KEY1;
          else begin nxt = S_IDLE; nx_bare = 1'b1; end
        S_KEY2:
          if (hit_a && wr_data == OP_PROG) begin nxt = S_LOAD; nx_prog = 1'b1; end
          else if (hit_a && wr_data == OP_ID_IN) begin nxt = S_IDLE; nx_in = 1'b1; end
          else if (hit_a && wr_data == OP_ID_OUT) begin nxt = S_IDLE; nx_out = 1'b1; end
          else if (is_first) nxt = S_KEY1;
          else begin nxt = S_IDLE; nx_bare = 1'b1; end
        default:
          if (is_first) nxt = S_KEY1;
          else begin nxt = S_IDLE; nx_bare = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      program_enable <= 1'b0;
      id_enter       <= 1'b0;
      id_exit        <= 1'b0;
      bare_write     <= 1'b0;
      id_mode        <= 1'b0;
    end else begin
      st             <= nxt;
      program_enable <= nx_prog;
      id_enter       <= nx_in;
      id_exit        <= nx_out;
      bare_write     <= nx_bare;
      if (nx_in) id_mode <= 1'b1;
      else if (nx_out) id_mode <= 1'b0;
    end
  end

  assign id_data = !id_mode ? '0 : (rd_addr[0] ? DEV_CODE : MFR_CODE);
endmodule

// File: rtl/unlock_seq_checker.sv
module unlock_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       program_enable,
  input logic       id_enter,
  input logic       id_exit,
  input logic       bare_write,
  input logic       id_mode
);
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({program_enable, id_enter, id_exit, bare_write}));

  p_pulse_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (program_enable || id_enter || id_exit || bare_write) |-> $past(wr_en));

  p_enter_sets_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter |-> id_mode);

  p_exit_clears_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit |-> !id_mode);

  p_mode_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> id_enter && $past(wr_data) == 8'h90);

  p_prog_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    program_enable |=> !program_enable);

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_enter && !id_exit) |-> $stable(id_mode) || $past(!rst_n));
endmodule

bind unlock_seq_decoder unlock_seq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .program_enable(program_enable), .id_enter(id_enter), .id_exit(id_exit),
  .bare_write(bare_write), .id_mode(id_mode)
);

// File: tb/test_unlock_seq_decoder.sv
`timescale 1ns/1ps
module test_unlock_seq_decoder;
  logic clk = 0, rst_n = 0, wr_en = 0, prog_done = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic program_enable, id_enter, id_exit, bare_write, id_mode;
  logic [7:0] id_data;

  int compared = 0, mismatched = 0;
  int m_st = 0;
  logic e_prog, e_in, e_out, e_bare, e_mode;

  always #4 clk = ~clk;

  unlock_seq_decoder i_unlock_seq_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done), .rd_addr(rd_addr), .program_enable(program_enable),
    .id_enter(id_enter), .id_exit(id_exit), .bare_write(bare_write),
    .id_mode(id_mode), .id_data(id_data));

  function automatic logic [7:0] exp_id(input logic mode, input logic a0);
    if (!mode) return 8'h00;
    return a0 ? 8'h3D : 8'h1F;
  endfunction

  function automatic logic low15(input logic [15:0] a, input logic [15:0] b);
    return a[14:0] == b[14:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model: 0 idle, 1 key1 seen, 2 key2 seen, 3 loading
  task automatic model_step(input logic w, input logic [15:0] a, input logic [7:0] d, input logic pd);
    logic first;
    e_prog = 0; e_in = 0; e_out = 0; e_bare = 0;
    if (m_st == 3 && pd) m_st = 0;
    first = low15(a, 16'h5555) && d == 8'hAA;
    if (w) begin
      if (m_st == 3) begin
      end else if (m_st == 1 && low15(a, 16'h2AAA) && d == 8'h55) m_st = 2;
      else if (m_st == 2 && low15(a, 16'h5555) && d == 8'hA0) begin m_st = 3; e_prog = 1; end
      else if (m_st == 2 && low15(a, 16'h5555) && d == 8'h90) begin m_st = 0; e_in = 1; e_mode = 1; end
      else if (m_st == 2 && low15(a, 16'h5555) && d == 8'hF0) begin m_st = 0; e_out = 1; e_mode = 0; end
      else if (first) m_st = 1;
      else begin m_st = 0; e_bare = 1; end
    end
  endtask

  task automatic cyc(input logic w, input logic [15:0] a, input logic [7:0] d, input logic pd, input string req);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; prog_done = pd;
    model_step(w, a, d, pd);
    @(posedge clk); #1;
    wr_en = 0; prog_done = 0;
    check({req, " prog"}, program_enable, e_prog);
    check({req, " id_enter"}, id_enter, e_in);
    check({req, " id_exit"}, id_exit, e_out);
    check({req, " bare"}, bare_write, e_bare);
    check({req, " mode"}, id_mode, e_mode);
  endtask

  task automatic unlock(input logic [7:0] op, input string req);
    cyc(1, 16'h5555, 8'hAA, 0, req);
    cyc(1, 16'h2AAA, 8'h55, 0, req);
    cyc(1, 16'h5555, op, 0, req);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    e_mode = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mode", id_mode, 0);
    check("R1 pulses", {program_enable, id_enter, id_exit, bare_write}, 0);
    check("R1 id_data", id_data, 0);
    @(negedge clk); rst_n = 1;

    unlock(8'hA0, "R3");
    check("R3 pulse seen", e_prog, 1);
    cyc(1, 16'h0123, 8'h42, 0, "R9 load no pulse");
    cyc(1, 16'h0124, 8'h43, 0, "R9 load no pulse");
    cyc(0, 0, 0, 1, "R9 prog_done");
    cyc(1, 16'h0125, 8'h44, 0, "R9 relock bare");
    check("R7 bare after relock", bare_write, 1);

    unlock(8'hA0, "R3");
    cyc(1, 16'h5555, 8'hAA, 1, "R9 done with write");

    cyc(1, 16'hD555, 8'hAA, 0, "R2 bit15 ignored");
    cyc(1, 16'hAAAA, 8'h55, 0, "R2 bit15 ignored");
    cyc(1, 16'hD555, 8'h90, 0, "R4");
    check("R4 mode set", id_mode, 1);
    rd_addr = 16'h0000; #1; check("R6 mfr", id_data, 8'h1F);
    rd_addr = 16'h0001; #1; check("R6 dev", id_data, 8'h3D);

    cyc(1, 16'h5555, 8'hAA, 0, "R8");
    cyc(1, 16'h5555, 8'hAA, 0, "R8 rejudged first");
    cyc(1, 16'h2AAA, 8'h55, 0, "R8");
    cyc(1, 16'h5555, 8'h11, 0, "R8 bad op");
    check("R8 bare on bad op", bare_write, 1);

    unlock(8'hF0, "R5");
    check("R5 mode cleared", id_mode, 0);
    rd_addr = 16'h0001; #1; check("R6 idle zero", id_data, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int ra = $urandom_range(0, 3);
      int rd = $urandom_range(0, 5);
      a = (ra == 0) ? 16'h5555 : (ra == 1) ? 16'h2AAA : (ra == 2) ? 16'hD555 : 16'($urandom);
      d = (rd == 0) ? 8'hAA : (rd == 1) ? 8'h55 : (rd == 2) ? 8'hA0 :
          (rd == 3) ? 8'h90 : (rd == 4) ? 8'hF0 : 8'($urandom);
      rd_addr = 16'($urandom);
      cyc($urandom_range(0, 9) < 7, a, d, $urandom_range(0, 19) == 0, "R10 random");
      check("R6 random id_data", id_data, exp_id(e_mode, rd_addr[0]));
    end

    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R1 reset clears mode", id_mode, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule